// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one 16-bit compare channel working against its own up-counting compare timer. Software reaches it through a byte-wide write port. A compare value is written one byte at a time into a visible holding register. A separate active latch holds the value the comparator really uses, and software has no direct path into that latch. In buffered mode, a write to the low byte arms a transfer of the whole holding register into the active latch. That transfer happens at the next timer overflow, so the value in use during the current period is never disturbed. In direct mode, which is the reset default, the low-byte write goes straight into the active latch. Using direct mode first and buffered mode second lets software preload both stages before the channel is enabled.

The timer has two named states. In `TMR_IDLE` it is stopped. A write to the reload low byte takes it to `TMR_RUN` (transition *start*). In `TMR_RUN` it counts from the reload value up to all ones, then reloads (transition *wrap*, which keeps it in `TMR_RUN`). A further reload-low write restarts the count (transition *restart*). The wrap cycle produces a one-cycle overflow pulse, which does two things: it moves an armed value into the active latch, and it pulls the output low. A compare match drives the output high. The result is a PWM waveform whose high time runs from the match to the end of the period. Software can force the output to either level at any time. While the channel is disabled, the output keeps its forced level.

Top module: `cmp_channel`

## Requirements
- R1: After reset, `cmp_pin` is 0, the timer is stopped, the mode is direct and the channel is disabled. With no writes, `cmp_pin` stays 0.
- R2: In direct mode (control bit 0 = 0), a write to address 0 loads the active latch with {holding high byte, written byte} at that same clock edge. A match against the new value is possible from the next cycle.
- R3: In buffered mode (control bit 0 = 1), a write to address 0 only updates the holding register and arms a transfer. The active latch changes only at a timer overflow, so the current period still uses the old value.
- R4: At an overflow, no transfer takes place unless a low-byte write has armed one since the last transfer. A high-byte write (address 1) on its own never reaches the active latch.
- R5: The value committed by a low-byte write is the high byte written earlier at address 1, paired with the low byte now written.
- R6: A buffered low-byte write in the same cycle as an overflow is not used at that overflow. It is transferred at the following overflow. The armed flag clears when a transfer happens.
- R7: A write to address 3 loads the timer with {pending reload high byte from address 4, written byte} and starts it. The timer counts up by one each cycle to 16'hFFFF and then reloads, giving a period of 65536 - reload cycles.
- R8: When enabled (control bit 1 = 1), the output goes high on the edge after the timer equals the active value. It goes low on the edge after an overflow, and the overflow wins if both occur together.
- R9: A write to the control register (address 2) with bit 2 set forces `cmp_pin` to the level given by bit 3 at that edge. The force takes priority over match and overflow.
- R10: While disabled, matches and overflows leave `cmp_pin` unchanged. Writes still update the holding register, the active latch and the armed flag according to the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 compare low, 1 compare high, 2 control, 3 reload low, 4 reload high |
| wr_data | input | 8 | Write data byte |
| cmp_pin | output | 1 | Compare output |

## Verification
Every result appears on the edge that consumes the stimulus:
- A force, a match or an overflow changes `cmp_pin` one edge later.
- A direct-mode write can cause a match from the following cycle.
- A buffered write takes effect only at the overflow edge that ends its period.

The bench drives inputs on falling edges. A behavioural model replays each rising edge, and `cmp_pin` is compared with that model on every falling edge, so each one-edge latency is checked exactly. Dedicated checks add an independent measurement of the PWM period and fixed expected levels after reset and while the channel is disabled.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    localparam int CTL_BUF_BIT   = 0;
    localparam int CTL_EN_BIT    = 1;
    localparam int CTL_FORCE_BIT = 2;
    localparam int CTL_LVL_BIT   = 3;
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB     = CNT_W / BYTE_W,
    localparam int ADDR_W = $clog2(2 * NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ovf,
    output logic [CNT_W-1:0]  active_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  start_val,
    output logic              start,
    output logic              enable,
    output logic              force_wr,
    output logic              force_lvl
);
    import cmp_pkg::*;

    localparam logic [ADDR_W-1:0] A_CMP0 = '0;
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(NB);
    localparam logic [ADDR_W-1:0] A_RLD0 = ADDR_W'(NB + 1);

    logic [CNT_W-1:0]  hold_q;
    logic [CNT_W-1:0]  rld_pend;
    logic              armed_q;
    logic              buffered;
    logic              cmp_lo_wr;
    logic              ctl_wr;
    logic              direct_wr;

    assign cmp_lo_wr = wr_en && (wr_addr == A_CMP0);
    assign ctl_wr    = wr_en && (wr_addr == A_CTL);
    assign start     = wr_en && (wr_addr == A_RLD0);
    assign direct_wr = cmp_lo_wr && !buffered;
    assign force_wr  = ctl_wr && wr_data[CTL_FORCE_BIT];
    assign force_lvl = wr_data[CTL_LVL_BIT];
    assign start_val = {rld_pend[CNT_W-1:BYTE_W], wr_data};

    // Upper byte lanes of the holding register and the pending reload
    for (genvar k = 1; k < NB; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[k*BYTE_W +: BYTE_W]   <= '0;
                rld_pend[k*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(k))
                    hold_q[k*BYTE_W +: BYTE_W] <= wr_data;
                if (wr_addr == ADDR_W'(NB + 1 + k))
                    rld_pend[k*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    assign rld_pend[BYTE_W-1:0] = '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q[BYTE_W-1:0] <= '0;
        end else if (cmp_lo_wr) begin
            hold_q[BYTE_W-1:0] <= wr_data;
        end
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buffered <= 1'b0;
            enable   <= 1'b0;
        end else if (ctl_wr) begin
            buffered <= wr_data[CTL_BUF_BIT];
            enable   <= wr_data[CTL_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (start) begin
            reload_q <= start_val;
        end
    end

    // Active latch and transfer arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            if (direct_wr)
                active_q <= {hold_q[CNT_W-1:BYTE_W], wr_data};
            else if (ovf && armed_q)
                active_q <= hold_q;

            if (cmp_lo_wr)
                armed_q <= buffered;
            else if (ovf)
                armed_q <= 1'b0;
        end
    end

    assert_buf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !direct_wr) |=> $stable(active_q));

    assert_no_arm_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !armed_q && !direct_wr) |=> $stable(active_q));

    assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        direct_wr |=> (active_q[BYTE_W-1:0] == $past(wr_data)));

    assert_same_cycle_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && cmp_lo_wr && buffered) |=> armed_q);

    assert_arm_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cmp_lo_wr) |=> !armed_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             ovf
);
    import cmp_pkg::*;

    tmr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (start) state_d = TMR_RUN;
            TMR_RUN:  state_d = TMR_RUN;
            default:  state_d = TMR_IDLE;
        endcase
    end

    always_comb begin
        running = (state_q == TMR_RUN);
        ovf     = running && (count == {CNT_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (start)    count <= start_val;
        else if (ovf)      count <= reload_q;
        else if (running)  count <= count + 1'b1;
    end

    assert_wrap_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !start) |=> (count == $past(reload_q)));

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ovf && !start) |=> (count == $past(count) + 1'b1));

    assert_idle_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(count));
endmodule

// File: rtl/cmp_out_ctl.sv
module cmp_out_ctl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_wr,
    input  logic             force_lvl,
    input  logic             enable,
    input  logic             running,
    input  logic             ovf,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] active_q,
    output logic             pin
);
    logic match;

    assign match = running && (count == active_q);

    always_ff @(posedge clk) begin
        if (!rst_n)              pin <= 1'b0;
        else if (force_wr)       pin <= force_lvl;
        else if (enable && ovf)  pin <= 1'b0;
        else if (enable && match) pin <= 1'b1;
    end

    assert_ovf_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ovf && !force_wr) |=> !pin);

    assert_match_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && match && !ovf && !force_wr) |=> pin);

    assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> (pin == $past(force_lvl)));

    assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !force_wr) |=> $stable(pin));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB     = CNT_W / BYTE_W,
    localparam int ADDR_W = $clog2(2 * NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              cmp_pin
);
    logic [CNT_W-1:0] active_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] count;
    logic             start;
    logic             enable;
    logic             force_wr;
    logic             force_lvl;
    logic             running;
    logic             ovf;

    cmp_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ovf       (ovf),
        .active_q  (active_q),
        .reload_q  (reload_q),
        .start_val (start_val),
        .start     (start),
        .enable    (enable),
        .force_wr  (force_wr),
        .force_lvl (force_lvl)
    );

    cmp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_val (start_val),
        .reload_q  (reload_q),
        .count     (count),
        .running   (running),
        .ovf       (ovf)
    );

    cmp_out_ctl #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_wr  (force_wr),
        .force_lvl (force_lvl),
        .enable    (enable),
        .running   (running),
        .ovf       (ovf),
        .count     (count),
        .active_q  (active_q),
        .pin       (cmp_pin)
    );
endmodule

// File: tb/test_cmp_channel.sv
module test_cmp_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cmp_pin;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit cmp_on = 0;
    string tag = "R1";

    // reference model state
    int m_hold, m_act, m_armed, m_buf, m_en, m_rpend, m_rld, m_cnt, m_run, m_out;

    always #4 clk = ~clk;

    cmp_channel i_cmp_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_pin(cmp_pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_hold = 0; m_act = 0; m_armed = 0; m_buf = 0; m_en = 0;
            m_rpend = 0; m_rld = 0; m_cnt = 0; m_run = 0; m_out = 0;
        end else begin
            int ovf, n_out, n_act, n_armed, n_cnt, n_run, d;
            d = int'(wr_data);
            ovf = (m_run != 0 && m_cnt == 65535) ? 1 : 0;
            n_out = m_out;
            if (m_en != 0 && ovf != 0) n_out = 0;
            else if (m_en != 0 && m_run != 0 && m_cnt == m_act) n_out = 1;
            if (wr_en && wr_addr == 2 && wr_data[2]) n_out = int'(wr_data[3]);
            n_act = m_act;
            if (ovf != 0 && m_armed != 0) n_act = m_hold;
            n_armed = (ovf != 0) ? 0 : m_armed;
            if (wr_en && wr_addr == 0) begin
                if (m_buf == 0) n_act = (m_hold & 32'hFF00) | d;
                n_armed = m_buf;
            end
            n_run = m_run;
            n_cnt = m_cnt;
            if (m_run != 0) n_cnt = (ovf != 0) ? m_rld : m_cnt + 1;
            if (wr_en && wr_addr == 3) begin
                n_cnt = (m_rpend << 8) | d;
                n_run = 1;
                m_rld = n_cnt;
            end
            if (wr_en && wr_addr == 0) m_hold = (m_hold & 32'hFF00) | d;
            if (wr_en && wr_addr == 1) m_hold = (m_hold & 32'h00FF) | (d << 8);
            if (wr_en && wr_addr == 4) m_rpend = d;
            if (wr_en && wr_addr == 2) begin
                m_buf = int'(wr_data[0]);
                m_en  = int'(wr_data[1]);
            end
            m_out = n_out; m_act = n_act; m_armed = n_armed;
            m_cnt = n_cnt; m_run = n_run;
        end
        if (cyc > 100000 && !done) begin
            check(0, "watchdog", cyc, 100000);
            finish_sim();
        end
    end

    // compare with the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on)
            check(cmp_pin === m_out[0], tag, int'(cmp_pin), m_out);
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int t_rise0, t_rise1;
        bit prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1: reset state
        tag = "R1";
        idle(2);
        check(cmp_pin === 1'b0, "R1", int'(cmp_pin), 0);
        idle(10);
        check(cmp_pin === 1'b0, "R1", int'(cmp_pin), 0);

        // R2 / R5: direct preload, high byte first
        tag = "R2";
        wr(1, 8'hFF); wr(0, 8'hF4);
        tag = "R3";
        wr(2, 8'h01);                 // buffered mode
        wr(1, 8'hFF); wr(0, 8'hFA);  // second-period value
        wr(2, 8'h07);                 // enable, buffered, force low
        check(cmp_pin === 1'b0, "R9", int'(cmp_pin), 0);
        tag = "R7";
        wr(4, 8'hFF); wr(3, 8'hF0);  // start timer, period 16
        idle(40);

        // R7/R8: independent period measurement between rising edges
        prev = cmp_pin; t_rise0 = -1; t_rise1 = -1;
        for (int i = 0; i < 60 && t_rise1 < 0; i++) begin
            @(negedge clk);
            if (cmp_pin && !prev) begin
                if (t_rise0 < 0) t_rise0 = i; else t_rise1 = i;
            end
            prev = cmp_pin;
        end
        check(t_rise1 - t_rise0 == 16, "R7", t_rise1 - t_rise0, 16);

        // R4: high byte only, no arming
        tag = "R4";
        wr(1, 8'hF8);
        idle(40);

        // R5: commit a new pair
        tag = "R5";
        wr(1, 8'hFF); wr(0, 8'hF6);
        idle(40);

        // R6: low write in the overflow cycle
        tag = "R6";
        wr(1, 8'hFF);
        do @(negedge clk); while (m_cnt != 65535);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hFC;
        @(negedge clk);
        wr_en = 1'b0;
        idle(40);

        // R9: forcing mid-period
        tag = "R9";
        wr(2, 8'h0F);
        check(cmp_pin === 1'b1, "R9", int'(cmp_pin), 1);
        wr(2, 8'h07);
        check(cmp_pin === 1'b0, "R9", int'(cmp_pin), 0);
        idle(20);

        // R10: disabled, forced high, writes still land
        tag = "R10";
        wr(2, 8'h0D);
        wr(1, 8'hFF); wr(0, 8'hF2);
        idle(40);
        check(cmp_pin === 1'b1, "R10", int'(cmp_pin), 1);
        wr(2, 8'h03);
        idle(40);

        // R2: direct write while running takes effect at once
        tag = "R2";
        wr(2, 8'h02);
        wr(1, 8'hFF); wr(0, 8'hF8);
        idle(40);
        wr(0, 8'hF3);
        idle(40);

        // R7: restart with a new reload value
        tag = "R7";
        wr(4, 8'hFF); wr(3, 8'hE8);
        idle(80);

        finish_sim();
    end
endmodule